// File: doc/BRIEF.md
# Descriptor Reload Unit

When a DMA channel has moved its last element, this unit refills the channel's working registers from a descriptor held in memory. Outside logic detects that the channel's count has reached zero. It then pulses a start strobe carrying the channel number, the channel's current link pointer and the channel's current interrupt-on-completion bit.

If the pointer is nonzero, the unit fetches four 32-bit words. It fetches them one at a time over a request/acknowledge read port, always addressing from the old pointer. It then hands the results to the register file through a single write port. The descriptor holds its words in the order source, destination, next pointer, control, which differs from the order in which the registers are written.

A zero pointer ends the chain. No memory access is made, and a single write clears the channel's enable bit.

While the unit works, a one-hot busy mask keeps the channel arbiter away from the channel being rebuilt. A done pulse carries the completion-interrupt decision.

Top module: `desc_reload_unit`

## Requirements
- R1: After reset the unit is idle: busy_o, busy_mask_o, rd_req_o, wr_en_o, done_o and tc_irq_o are all low.
- R2: A start_i pulse seen while idle is accepted at that clock edge. From the next cycle busy_o is high and busy_mask_o has exactly the bit of start_chan_i set, until done_o has been seen.
- R3: When the captured link pointer is zero, no read is issued. The only register write is one with wr_sel_o = 4 (clear enable), wr_data_o = 0 and wr_chan_o equal to the started channel.
- R4: When the link pointer L is nonzero, exactly four reads are issued, at L, L+4, L+8 and L+12 in that order. Each request, with its address, is held until rd_ack_i, and the next request follows only after that acknowledge.
- R5: The word read at L is written with wr_sel_o = 0 (source) and the word at L+4 with wr_sel_o = 1 (destination), each in the cycle after its acknowledge. The word at L+12 is written with wr_sel_o = 3 (control) in the cycle after its acknowledge. All writes carry the started channel.
- R6: The word read at L+8 is written with wr_sel_o = 2 (link) only in the cycle after the control write. It is the last write of a reload, so every read uses the old pointer.
- R7: done_o is high for exactly one cycle, in the cycle after the last register write, and busy_o is low in the cycle after. With done_o, tc_irq_o equals bit 31 of the newly loaded control word, or the start-time cur_tc_irq_i when the pointer was zero.
- R8: A start_i pulse while busy_o is high is ignored: it causes no extra read or write and does not change busy_mask_o.
- R9: Read data is little-endian. Byte lane k of rd_data_i (bits 8k+7:8k) holds the byte at address+k, and the byte at the lowest address becomes the least significant byte of the written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe: a channel's count reached zero |
| start_chan_i | input | CHW | Channel index for the start strobe |
| link_ptr_i | input | AW | Channel's current link pointer |
| cur_tc_irq_i | input | 1 | Channel's current completion-interrupt bit |
| busy_o | output | 1 | Reload in progress |
| busy_mask_o | output | NCHAN | One-hot mask of the channel under reload |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read byte address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data, byte lanes |
| wr_en_o | output | 1 | Register write strobe |
| wr_chan_o | output | CHW | Channel of the register write |
| wr_sel_o | output | 3 | Target: 0 source, 1 destination, 2 link, 3 control, 4 clear enable |
| wr_data_o | output | 32 | Register write data |
| done_o | output | 1 | Reload finished |
| tc_irq_o | output | 1 | Completion-interrupt decision, valid with done_o |

## Verification
The embedded assertions watch, on every cycle, that a pending request keeps its address until acknowledged and that reads and writes never share a cycle. They also check that the link write directly follows the control write, that done follows a write and lasts one cycle, and that the busy mask stays one-hot and steady while busy. Whether the right words reach the right registers, the exact address sequence and the absence of reads for a zero pointer can only be shown by the bench. The same holds for little-endian byte assembly, the interrupt decision and the rejection of starts during a reload. The bench shows them by comparing against a byte-level memory model under several response latencies.

// File: rtl/desc_reload_pkg.sv
package desc_reload_pkg;

   // Register file targets of the write port; the encoding is visible on wr_sel_o.
   typedef enum logic [2:0] {
      TGT_SRC    = 3'd0,
      TGT_DST    = 3'd1,
      TGT_LINK   = 3'd2,
      TGT_CTRL   = 3'd3,
      TGT_CLR_EN = 3'd4
   } wr_tgt_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_LINK,
      ST_END,
      ST_DONE
   } rl_state_e;

   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned WORD_BITS  = 32;
   localparam int unsigned IRQ_BIT    = 31;

endpackage

// File: rtl/desc_addr_gen.sv
module desc_addr_gen #(
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 2
) (
   input  logic [AW-1:0]    base_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [AW-1:0]    addr_o
);
   localparam int unsigned OFF_W = IDX_W + 2;

   if (AW < OFF_W) begin : g_bad_aw
      $error("desc_addr_gen: AW too small for descriptor offsets");
   end

   logic [AW-1:0] offset;

   always_comb begin
      offset = '0;
      offset[OFF_W-1:0] = {idx_i, 2'b00};
   end

   assign addr_o = base_i + offset;

endmodule

// File: rtl/desc_chan_decode.sv
module desc_chan_decode #(
   parameter int unsigned NCHAN = 8,
   parameter int unsigned CHW   = 3
) (
   input  logic             en_i,
   input  logic [CHW-1:0]   chan_i,
   output logic [NCHAN-1:0] mask_o
);
   for (genvar c = 0; c < NCHAN; c++) begin : g_bit
      assign mask_o[c] = en_i && (chan_i == CHW'(c));
   end
endmodule

// File: rtl/desc_reload_unit.sv
module desc_reload_unit
   import desc_reload_pkg::*;
#(
   parameter int unsigned NCHAN = 8,
   parameter int unsigned AW    = 32,
   localparam int unsigned CHW  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CHW-1:0]   start_chan_i,
   input  logic [AW-1:0]    link_ptr_i,
   input  logic             cur_tc_irq_i,
   output logic             busy_o,
   output logic [NCHAN-1:0] busy_mask_o,
   output logic             rd_req_o,
   output logic [AW-1:0]    rd_addr_o,
   input  logic             rd_ack_i,
   input  logic [31:0]      rd_data_i,
   output logic             wr_en_o,
   output logic [CHW-1:0]   wr_chan_o,
   output logic [2:0]       wr_sel_o,
   output logic [31:0]      wr_data_o,
   output logic             done_o,
   output logic             tc_irq_o
);
   localparam int unsigned IDX_W    = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_NEXT = IDX_W'(2);
   localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(3);

   if (NCHAN < 1 || NCHAN > 32) begin : g_bad_nchan
      $error("desc_reload_unit: NCHAN out of range");
   end
   if (AW < 8 || AW > WORD_BITS) begin : g_bad_aw
      $error("desc_reload_unit: AW must lie in 8..32");
   end

   rl_state_e        state_q;
   logic [CHW-1:0]   chan_q;
   logic [AW-1:0]    link_q;
   logic [IDX_W-1:0] idx_q;
   logic [31:0]      word_q;
   logic [31:0]      next_link_q;
   logic             irq_q;
   logic [31:0]      le_word;
   wr_tgt_e          tgt;

   // byte at the lowest address lands in the least significant byte
   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign le_word[8*b +: 8] = rd_data_i[8*b +: 8];
   end

   desc_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
      .base_i (link_q),
      .idx_i  (idx_q),
      .addr_o (rd_addr_o)
   );

   desc_chan_decode #(.NCHAN(NCHAN), .CHW(CHW)) u_mask (
      .en_i   (busy_o),
      .chan_i (chan_q),
      .mask_o (busy_mask_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         chan_q      <= '0;
         link_q      <= '0;
         idx_q       <= '0;
         word_q      <= '0;
         next_link_q <= '0;
         irq_q       <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  chan_q  <= start_chan_i;
                  link_q  <= link_ptr_i;
                  irq_q   <= cur_tc_irq_i;
                  idx_q   <= '0;
                  state_q <= (link_ptr_i == '0) ? ST_END : ST_READ;
               end
            end
            ST_READ: begin
               if (rd_ack_i) begin
                  if (idx_q == IDX_NEXT) begin
                     next_link_q <= le_word;
                     idx_q       <= IDX_CTRL;
                  end else begin
                     word_q  <= le_word;
                     state_q <= ST_WRITE;
                     if (idx_q == IDX_CTRL) irq_q <= le_word[IRQ_BIT];
                  end
               end
            end
            ST_WRITE: begin
               if (idx_q == IDX_CTRL) begin
                  state_q <= ST_LINK;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_READ;
               end
            end
            ST_LINK:  state_q <= ST_DONE;
            ST_END:   state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      tgt       = TGT_SRC;
      wr_en_o   = 1'b0;
      wr_data_o = '0;
      unique case (state_q)
         ST_WRITE: begin
            wr_en_o   = 1'b1;
            wr_data_o = word_q;
            unique case (idx_q)
               2'd0:    tgt = TGT_SRC;
               2'd1:    tgt = TGT_DST;
               default: tgt = TGT_CTRL;
            endcase
         end
         ST_LINK: begin
            wr_en_o   = 1'b1;
            wr_data_o = next_link_q;
            tgt       = TGT_LINK;
         end
         ST_END: begin
            wr_en_o = 1'b1;
            tgt     = TGT_CLR_EN;
         end
         default: ;
      endcase
   end

   assign wr_sel_o  = tgt;
   assign wr_chan_o = chan_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign rd_req_o  = (state_q == ST_READ);
   assign done_o    = (state_q == ST_DONE);
   assign tc_irq_o  = done_o && irq_q;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

   // R4
   no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_en_o));

   // R6
   link_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o && wr_sel_o == 3'd2 |-> $past(wr_en_o && wr_sel_o == 3'd3));

   // R3
   end_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o && wr_sel_o == 3'd4 |=> done_o);

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(wr_en_o));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   // R2
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> $onehot(busy_mask_o));

   // R8
   mask_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(busy_mask_o));

endmodule

// File: tb/tb_desc_reload_unit.sv
module tb_desc_reload_unit;
   localparam int NCHAN = 8;
   localparam int AW    = 32;
   localparam int CHW   = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CHW-1:0]   start_chan_i = '0;
   logic [AW-1:0]    link_ptr_i = '0;
   logic             cur_tc_irq_i = 1'b0;
   logic             busy_o;
   logic [NCHAN-1:0] busy_mask_o;
   logic             rd_req_o;
   logic [AW-1:0]    rd_addr_o;
   logic             rd_ack_i = 1'b0;
   logic [31:0]      rd_data_i = '0;
   logic             wr_en_o;
   logic [CHW-1:0]   wr_chan_o;
   logic [2:0]       wr_sel_o;
   logic [31:0]      wr_data_o;
   logic             done_o;
   logic             tc_irq_o;

   always #2 clk = ~clk;

   desc_reload_unit #(.NCHAN(NCHAN), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_chan_i(start_chan_i),
      .link_ptr_i(link_ptr_i), .cur_tc_irq_i(cur_tc_irq_i), .busy_o(busy_o),
      .busy_mask_o(busy_mask_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
      .wr_chan_o(wr_chan_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
      .done_o(done_o), .tc_irq_o(tc_irq_o)
   );

   int checks = 0;
   int failures = 0;
   int latency = 0;
   int lat_cnt = 0;
   int dones_seen = 0;
   int cycles = 0;
   logic [7:0]  mem_b [int];
   logic [31:0] exp_rd [$];
   logic [37:0] exp_wr [$];   // {sel[2:0], chan[2:0], data[31:0]}
   logic        exp_done [$];
   logic        last_wr_valid = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // monitor and memory model, one process at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en_o) begin
            if (exp_wr.size() == 0) begin
               check(1'b0, "R8", "unexpected write", {29'd0, wr_sel_o, wr_data_o}, 64'd0);
            end else begin
               logic [37:0] e;
               e = exp_wr.pop_front();
               check({wr_sel_o, wr_chan_o, wr_data_o} == e, "R5/R6/R9", "write",
                     {26'd0, wr_sel_o, wr_chan_o, wr_data_o}, {26'd0, e});
            end
         end
         if (done_o) begin
            // R7: done follows a write directly
            check(last_wr_valid, "R7", "done without preceding write", 64'(last_wr_valid), 64'd1);
            if (exp_done.size() == 0) begin
               check(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
            end else begin
               logic ei;
               ei = exp_done.pop_front();
               check(tc_irq_o == ei, "R7", "tc_irq", 64'(tc_irq_o), 64'(ei));
            end
            dones_seen++;
         end
         last_wr_valid = wr_en_o;
      end
      if (rd_ack_i) begin
         rd_ack_i = 1'b0;
         lat_cnt  = 0;
      end else if (rst_n && rd_req_o) begin
         if (lat_cnt >= latency) begin
            if (exp_rd.size() == 0) begin
               check(1'b0, "R3", "unexpected read", 64'(rd_addr_o), 64'd0);
            end else begin
               logic [31:0] ea;
               ea = exp_rd.pop_front();
               check(rd_addr_o == ea, "R4", "read address", 64'(rd_addr_o), 64'(ea));
            end
            for (int k = 0; k < 4; k++)
               rd_data_i[8*k +: 8] = mem_b.exists(int'(rd_addr_o) + k) ? mem_b[int'(rd_addr_o) + k] : 8'h00;
            rd_ack_i = 1'b1;
         end else begin
            lat_cnt++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         check(1'b0, "R7", "watchdog expired", 64'(cycles), 64'd20000);
         finish_run();
      end
   end

   task automatic put_word(input logic [31:0] addr, input logic [31:0] w);
      for (int k = 0; k < 4; k++) mem_b[int'(addr) + k] = w[8*k +: 8];
   endtask

   // driver: loads memory, pushes expectations, pulses start
   task automatic launch(input logic [2:0] ch, input logic [31:0] link,
                         input logic cur_irq, input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3);
      if (link == 0) begin
         exp_wr.push_back({3'd4, ch, 32'd0});
         exp_done.push_back(cur_irq);
      end else begin
         put_word(link, w0); put_word(link + 4, w1);
         put_word(link + 8, w2); put_word(link + 12, w3);
         for (int i = 0; i < 4; i++) exp_rd.push_back(link + 32'(4 * i));
         exp_wr.push_back({3'd0, ch, w0});
         exp_wr.push_back({3'd1, ch, w1});
         exp_wr.push_back({3'd3, ch, w3});
         exp_wr.push_back({3'd2, ch, w2});
         exp_done.push_back(w3[31]);
      end
      @(negedge clk);
      start_i = 1'b1; start_chan_i = ch; link_ptr_i = link; cur_tc_irq_i = cur_irq;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R2", "busy after start", 64'(busy_o), 64'd1);
      check(busy_mask_o == NCHAN'(1) << ch, "R2", "busy mask",
            64'(busy_mask_o), 64'(NCHAN'(1) << ch));
   endtask

   task automatic wait_done(input int target);
      while (dones_seen < target) @(negedge clk);
      @(negedge clk);
      check(busy_o == 1'b0, "R7", "idle after done", 64'(busy_o), 64'd0);
      check(exp_wr.size() == 0 && exp_rd.size() == 0, "R4/R5", "expectations drained",
            64'(exp_wr.size() + exp_rd.size()), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy_o && busy_mask_o == '0, "R1", "busy at reset", {busy_mask_o, 7'd0, busy_o}, 64'd0);
      check(!rd_req_o && !wr_en_o && !done_o && !tc_irq_o, "R1", "strobes at reset",
            {rd_req_o, wr_en_o, done_o, tc_irq_o}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 R5 R6 R9: reload with immediate responses, irq bit set
      latency = 0;
      launch(3'd3, 32'h0000_1000, 1'b0, 32'h8A3C_51E7, 32'h0102_0304, 32'h0000_2040, 32'h8000_0010);
      wait_done(1);

      // R4 R7: slow responses, irq bit clear in new control
      latency = 3;
      launch(3'd0, 32'h0000_2040, 1'b1, 32'hDEAD_BEEF, 32'h55AA_00FF, 32'h0000_0000, 32'h7FFF_FFFF);
      wait_done(2);

      // R3 R7: zero link ends the chain, old irq bit reported
      launch(3'd5, 32'h0, 1'b1, '0, '0, '0, '0);
      wait_done(3);
      launch(3'd1, 32'h0, 1'b0, '0, '0, '0, '0);
      wait_done(4);

      // R8: start for another channel during a reload is ignored
      latency = 2;
      launch(3'd7, 32'h0000_3000, 1'b0, 32'h1111_2222, 32'h3333_4444, 32'h0000_3010, 32'hC000_0001);
      repeat (3) @(negedge clk);
      start_i = 1'b1; start_chan_i = 3'd2; link_ptr_i = 32'h0; cur_tc_irq_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_mask_o == 8'h80, "R8", "mask unchanged by busy start", 64'(busy_mask_o), 64'h80);
      wait_done(5);

      // R2: back-to-back start right after done
      latency = 1;
      launch(3'd6, 32'h0000_3010, 1'b1, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h0000_0000, 32'h0000_0007);
      wait_done(6);

      repeat (4) @(negedge clk);
      check(dones_seen == 6, "R8", "done count", 64'(dones_seen), 64'd6);
      finish_run();
   end

endmodule